// File: doc/BRIEF.md
# Programmable Almost-Flag Threshold Unit

This block turns the occupancy count of a FIFO into three registered, active-low status flags: almost-empty, half-full and almost-full. Two offset registers set the almost thresholds. The empty offset n sets how close to empty the almost-empty flag switches. The full offset m sets how close to full the almost-full flag switches. The FIFO storage, its pointers and its counters are outside the block. The block receives a write-side count and a read-side count and returns the flags.

Two inputs are captured only while reset is held. The first is the load-method select. It picks the interface that programs the offsets, either a serial bit stream or a parallel word strobe, and it also picks the default offsets loaded at reset. The second is the read-timing select. In fall-through timing, one word sits in the output register, so every threshold moves up by one word. The almost-empty flag is registered on the read clock. The half-full and almost-full flags are registered on the write clock. The offsets are expected to be reprogrammed only while the FIFO is idle.

Top module: `almost_flag_unit`

## Requirements
- R1: The load-method select `ld_serial` is captured only while reset is active. When it is 1, only the serial port (`ser_en`/`ser_din`) may change the offsets and `par_we` has no effect. When it is 0, only `par_we`/`par_din` may change the offsets and `ser_en` has no effect.
- R2: After a reset with `ld_serial`=1, both offsets hold 1023.
- R3: After a reset with `ld_serial`=0, both offsets hold 127.
- R4: In standard timing (`fwft_sel`=0 at reset), `almost_empty_n` is 0 when `rd_count` <= n and 1 otherwise.
- R5: In fall-through timing (`fwft_sel`=1 at reset), `almost_empty_n` is 0 when `rd_count` <= n+1 and 1 otherwise.
- R6: With depth D, `almost_full_n` is 0 when `wr_count` >= D-m in standard timing, or when `wr_count` >= D+1-m in fall-through timing. It is 1 otherwise.
- R7: `half_full_n` is 0 when `wr_count` >= D/2+1 in standard timing, or when `wr_count` >= D/2+2 in fall-through timing. It is 1 otherwise.
- R8: Serial programming takes one bit of `ser_din` at each `clk_wr` edge where `ser_en`=1. The bits come least significant first: the OFS_W bits of n, then the OFS_W bits of m. After 2*OFS_W bits the sequence starts again at bit 0 of n.
- R9: Parallel programming writes `par_din` at each `clk_wr` edge where `par_we`=1. The writes alternate between targets: the first after reset goes to n, the next to m, the one after that to n again, and so on.
- R10: While reset is active the flags read `almost_empty_n`=0, `half_full_n`=1 and `almost_full_n`=1. Once reset has been released, each flag shows the count that was present at the previous edge of its own clock.
- R11: Changing `fwft_sel` after reset has no effect on the thresholds until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr | input | 1 | Write-side clock: offsets, half-full, almost-full |
| clk_rd | input | 1 | Read-side clock: almost-empty |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| ld_serial | input | 1 | Load-method select, captured during reset (1 serial, 0 parallel) |
| fwft_sel | input | 1 | Read-timing select, captured during reset (1 fall-through) |
| ser_en | input | 1 | Serial offset bit enable |
| ser_din | input | 1 | Serial offset bit |
| par_we | input | 1 | Parallel offset write strobe |
| par_din | input | OFS_W | Parallel offset value |
| wr_count | input | DEPTH_LOG2+1 | Occupancy count seen on the write side |
| rd_count | input | DEPTH_LOG2+1 | Occupancy count seen on the read side |
| almost_empty_n | output | 1 | Active-low almost-empty flag |
| half_full_n | output | 1 | Active-low half-full flag |
| almost_full_n | output | 1 | Active-low almost-full flag |

## Verification
The offsets and the captured modes are not visible at the ports, so the bench reads them through the flag thresholds. It drives counts one word on each side of every switching point.

- A wrong offset bit, or a wrong target in the parallel alternation, moves the edge of a flag. That edge then shows up wrong at the first count placed on the boundary, one edge after the count is applied.
- A mode captured wrongly, or captured after reset, moves all three thresholds by exactly one word.
- An input that leaks through from the interface that was not selected shows up at the next boundary probe.

// File: rtl/almflag_pkg.sv
`timescale 1ns/1ps
package almflag_pkg;
  // Configuration captured while reset is held
  typedef struct packed {
    logic serial;  // 1: serial offset loading, 0: parallel
    logic fwft;    // 1: fall-through read timing
  } cfg_t;

  // Direction of a threshold comparison
  typedef enum logic {
    CMP_AT_MOST  = 1'b0,
    CMP_AT_LEAST = 1'b1
  } cmp_kind_e;
endpackage

// File: rtl/almflag_rst_sync.sv
`timescale 1ns/1ps
module almflag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/almflag_cfg.sv
`timescale 1ns/1ps
module almflag_cfg
  import almflag_pkg::*;
#(
  parameter int OFS_W   = 10,
  parameter int DEF_SER = 1023,
  parameter int DEF_PAR = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_serial,
  input  logic             fwft_sel,
  input  logic             ser_en,
  input  logic             ser_din,
  input  logic             par_we,
  input  logic [OFS_W-1:0] par_din,
  output cfg_t             cfg,
  output logic [OFS_W-1:0] ofs_e,
  output logic [OFS_W-1:0] ofs_f
);
  localparam int BITS  = 2 * OFS_W;
  localparam int IDX_W = $clog2(BITS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BITS - 1);

  cfg_t             cfg_q, cfg_d;
  logic [OFS_W-1:0] ofs_e_q, ofs_e_d, ofs_f_q, ofs_f_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             sel_q, sel_d;
  logic             ser_ld, par_ld;

  assign ser_ld = cfg_q.serial & ser_en;
  assign par_ld = ~cfg_q.serial & par_we;

  // Next state: capture config and defaults while in reset,
  // afterwards accept only the selected load interface.
  always_comb begin
    cfg_d   = cfg_q;
    ofs_e_d = ofs_e_q;
    ofs_f_d = ofs_f_q;
    idx_d   = idx_q;
    sel_d   = sel_q;
    if (!rst_n) begin
      cfg_d.serial = ld_serial;
      cfg_d.fwft   = fwft_sel;
      ofs_e_d      = ld_serial ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR);
      ofs_f_d      = ld_serial ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR);
    end else if (ser_ld) begin
      for (int b = 0; b < OFS_W; b++) begin
        if (idx_q == IDX_W'(b))         ofs_e_d[b] = ser_din;
        if (idx_q == IDX_W'(b + OFS_W)) ofs_f_d[b] = ser_din;
      end
      idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end else if (par_ld) begin
      if (!sel_q) ofs_e_d = par_din;
      else        ofs_f_d = par_din;
      sel_d = ~sel_q;
    end
  end

  // Configuration and offsets are loaded synchronously during reset
  always_ff @(posedge clk) begin
    cfg_q   <= cfg_d;
    ofs_e_q <= ofs_e_d;
    ofs_f_q <= ofs_f_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sel_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      sel_q <= sel_d;
    end
  end

  assign cfg   = cfg_q;
  assign ofs_e = ofs_e_q;
  assign ofs_f = ofs_f_q;
endmodule

// File: rtl/almflag_cmp.sv
`timescale 1ns/1ps
module almflag_cmp
  import almflag_pkg::*;
#(
  parameter int        CNT_W   = 13,
  parameter cmp_kind_e KIND    = CMP_AT_LEAST,
  parameter logic      RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] thresh,
  output logic             flag_n
);
  logic hit;
  logic flag_d;

  generate
    if (KIND == CMP_AT_MOST) begin : g_at_most
      assign hit = (count <= thresh);
    end else begin : g_at_least
      assign hit = (count >= thresh);
    end
  endgenerate

  always_comb begin
    flag_d = ~hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_n <= RST_VAL;
    else        flag_n <= flag_d;
  end
endmodule

// File: rtl/almost_flag_unit.sv
`timescale 1ns/1ps
module almost_flag_unit
  import almflag_pkg::*;
#(
  parameter int DEPTH_LOG2 = 12,
  parameter int OFS_W      = 10,
  parameter int DEF_SER    = 1023,
  parameter int DEF_PAR    = 127,
  localparam int CNT_W     = DEPTH_LOG2 + 1
) (
  input  logic             clk_wr,
  input  logic             clk_rd,
  input  logic             rst_n,
  input  logic             ld_serial,
  input  logic             fwft_sel,
  input  logic             ser_en,
  input  logic             ser_din,
  input  logic             par_we,
  input  logic [OFS_W-1:0] par_din,
  input  logic [CNT_W-1:0] wr_count,
  input  logic [CNT_W-1:0] rd_count,
  output logic             almost_empty_n,
  output logic             half_full_n,
  output logic             almost_full_n
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_LVL = CNT_W'(DEPTH / 2 + 1);

  logic             rst_w_n, rst_r_n;
  cfg_t             cfg;
  logic [OFS_W-1:0] ofs_e, ofs_f;
  logic [CNT_W-1:0] slip;
  logic [CNT_W-1:0] thr_ae, thr_hf, thr_af;

  almflag_rst_sync #(.STAGES(2)) u_rst_w (
    .clk(clk_wr), .rst_n(rst_n), .rst_sync_n(rst_w_n)
  );
  almflag_rst_sync #(.STAGES(2)) u_rst_r (
    .clk(clk_rd), .rst_n(rst_n), .rst_sync_n(rst_r_n)
  );

  almflag_cfg #(
    .OFS_W(OFS_W), .DEF_SER(DEF_SER), .DEF_PAR(DEF_PAR)
  ) u_cfg (
    .clk(clk_wr), .rst_n(rst_w_n), .ld_serial(ld_serial), .fwft_sel(fwft_sel),
    .ser_en(ser_en), .ser_din(ser_din), .par_we(par_we), .par_din(par_din),
    .cfg(cfg), .ofs_e(ofs_e), .ofs_f(ofs_f)
  );

  // Fall-through timing holds one extra word in the output register
  assign slip   = CNT_W'(cfg.fwft);
  assign thr_ae = CNT_W'(ofs_e) + slip;
  assign thr_hf = HALF_LVL + slip;
  assign thr_af = FULL_LVL - CNT_W'(ofs_f) + slip;

  almflag_cmp #(.CNT_W(CNT_W), .KIND(CMP_AT_MOST), .RST_VAL(1'b0)) u_ae (
    .clk(clk_rd), .rst_n(rst_r_n), .count(rd_count), .thresh(thr_ae),
    .flag_n(almost_empty_n)
  );
  almflag_cmp #(.CNT_W(CNT_W), .KIND(CMP_AT_LEAST), .RST_VAL(1'b1)) u_hf (
    .clk(clk_wr), .rst_n(rst_w_n), .count(wr_count), .thresh(thr_hf),
    .flag_n(half_full_n)
  );
  almflag_cmp #(.CNT_W(CNT_W), .KIND(CMP_AT_LEAST), .RST_VAL(1'b1)) u_af (
    .clk(clk_wr), .rst_n(rst_w_n), .count(wr_count), .thresh(thr_af),
    .flag_n(almost_full_n)
  );
endmodule

// File: rtl/almost_flag_unit_chk.sv
`timescale 1ns/1ps
module almost_flag_unit_chk
  import almflag_pkg::*;
#(
  parameter int DEPTH_LOG2 = 12,
  parameter int OFS_W      = 10,
  localparam int CNT_W     = DEPTH_LOG2 + 1
) (
  input logic             clk_wr,
  input logic             clk_rd,
  input logic             rst_w_n,
  input logic             rst_r_n,
  input logic             ser_en,
  input logic             par_we,
  input logic [CNT_W-1:0] wr_count,
  input logic [CNT_W-1:0] rd_count,
  input cfg_t             cfg,
  input logic [OFS_W-1:0] ofs_e,
  input logic [OFS_W-1:0] ofs_f,
  input logic             almost_empty_n,
  input logic             half_full_n,
  input logic             almost_full_n
);
  localparam logic [CNT_W-1:0] D_LVL    = CNT_W'(1 << DEPTH_LOG2);
  localparam logic [CNT_W-1:0] HALF_LO  = CNT_W'((1 << DEPTH_LOG2) / 2);
  localparam logic [CNT_W-1:0] HALF_HI  = CNT_W'((1 << DEPTH_LOG2) / 2 + 2);
  localparam logic [CNT_W-1:0] ZERO_LVL = '0;

  logic live_w, live_r;

  always_ff @(posedge clk_wr or negedge rst_w_n) begin
    if (!rst_w_n) live_w <= 1'b0;
    else          live_w <= 1'b1;
  end
  always_ff @(posedge clk_rd or negedge rst_r_n) begin
    if (!rst_r_n) live_r <= 1'b0;
    else          live_r <= 1'b1;
  end

  assert_hf_low_R7: assert property (@(posedge clk_wr) disable iff (!rst_w_n)
    (live_w && $past(wr_count) >= HALF_HI) |-> !half_full_n);

  assert_hf_high_R7: assert property (@(posedge clk_wr) disable iff (!rst_w_n)
    (live_w && $past(wr_count) <= HALF_LO) |-> half_full_n);

  assert_af_at_depth_R6: assert property (@(posedge clk_wr) disable iff (!rst_w_n)
    (live_w && $past(wr_count) >= D_LVL) |-> !almost_full_n);

  assert_ae_when_empty_R4: assert property (@(posedge clk_rd) disable iff (!rst_r_n)
    (live_r && $past(rd_count) == ZERO_LVL) |-> !almost_empty_n);

  assert_ofs_hold_R1: assert property (@(posedge clk_wr) disable iff (!rst_w_n)
    (!ser_en && !par_we) |=> ($stable(ofs_e) && $stable(ofs_f)));

  assert_mode_hold_R11: assert property (@(posedge clk_wr) disable iff (!rst_w_n)
    live_w |-> $stable(cfg));
endmodule

bind almost_flag_unit almost_flag_unit_chk #(
  .DEPTH_LOG2(DEPTH_LOG2), .OFS_W(OFS_W)
) u_chk (
  .clk_wr(clk_wr), .clk_rd(clk_rd), .rst_w_n(rst_w_n), .rst_r_n(rst_r_n),
  .ser_en(ser_en), .par_we(par_we), .wr_count(wr_count), .rd_count(rd_count),
  .cfg(cfg), .ofs_e(ofs_e), .ofs_f(ofs_f), .almost_empty_n(almost_empty_n),
  .half_full_n(half_full_n), .almost_full_n(almost_full_n)
);

// File: tb/almost_flag_unit_test.sv
`timescale 1ns/1ps
module almost_flag_unit_test;
  localparam int OFS_W = 10;
  localparam int CNT_W = 13;

  logic             clk;
  logic             rst_n, ld_serial, fwft_sel, ser_en, ser_din, par_we;
  logic [OFS_W-1:0] par_din;
  logic [CNT_W-1:0] wr_count, rd_count;
  logic             almost_empty_n, half_full_n, almost_full_n;

  int n_checks = 0;
  int n_fail   = 0;
  logic done   = 1'b0;

  almost_flag_unit uut (
    .clk_wr(clk), .clk_rd(clk), .rst_n(rst_n), .ld_serial(ld_serial),
    .fwft_sel(fwft_sel), .ser_en(ser_en), .ser_din(ser_din), .par_we(par_we),
    .par_din(par_din), .wr_count(wr_count), .rd_count(rd_count),
    .almost_empty_n(almost_empty_n), .half_full_n(half_full_n),
    .almost_full_n(almost_full_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // fw, ld, count, expected {ae_n, hf_n, af_n}; depth 4096
  typedef struct packed {
    logic        fw;
    logic        ld;
    logic [12:0] cnt;
    logic [2:0]  exp;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 13'd0,    3'b011},  // R3 R4 defaults 127
    '{1'b0, 1'b0, 13'd127,  3'b011},
    '{1'b0, 1'b0, 13'd128,  3'b111},
    '{1'b0, 1'b0, 13'd2048, 3'b111},  // R7
    '{1'b0, 1'b0, 13'd2049, 3'b101},
    '{1'b0, 1'b0, 13'd3968, 3'b101},  // R6
    '{1'b0, 1'b0, 13'd3969, 3'b100},
    '{1'b0, 1'b0, 13'd4096, 3'b100},
    '{1'b1, 1'b0, 13'd128,  3'b011},  // R5
    '{1'b1, 1'b0, 13'd129,  3'b111},
    '{1'b1, 1'b0, 13'd2049, 3'b111},
    '{1'b1, 1'b0, 13'd2050, 3'b101},
    '{1'b1, 1'b0, 13'd3969, 3'b101},
    '{1'b1, 1'b0, 13'd3970, 3'b100},
    '{1'b1, 1'b0, 13'd4097, 3'b100},
    '{1'b0, 1'b1, 13'd1023, 3'b011},  // R2 defaults 1023
    '{1'b0, 1'b1, 13'd1024, 3'b111},
    '{1'b0, 1'b1, 13'd3072, 3'b101},
    '{1'b0, 1'b1, 13'd3073, 3'b100},
    '{1'b1, 1'b1, 13'd1024, 3'b011},
    '{1'b1, 1'b1, 13'd1025, 3'b111},
    '{1'b1, 1'b1, 13'd3073, 3'b101},
    '{1'b1, 1'b1, 13'd3074, 3'b100}
  };

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] got;
    got = {almost_empty_n, half_full_n, almost_full_n};
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: flags {ae_n,hf_n,af_n} = %b, expected %b (count %0d)",
               req, got, exp, wr_count);
    end
  endtask

  task automatic do_reset(input logic fw, input logic ld);
    @(negedge clk);
    rst_n = 1'b0; fwft_sel = fw; ld_serial = ld;
    ser_en = 1'b0; par_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic probe(input int c, input string req, input logic [2:0] exp);
    wr_count = CNT_W'(c);
    rd_count = CNT_W'(c);
    @(negedge clk);
    check(req, exp);
  endtask

  task automatic shift_ofs(input int n, input int m);
    for (int i = 0; i < 2 * OFS_W; i++) begin
      ser_en  = 1'b1;
      ser_din = (i < OFS_W) ? n[i] : m[i - OFS_W];
      @(negedge clk);
    end
    ser_en = 1'b0;
  endtask

  task automatic par_write(input int v);
    par_we  = 1'b1;
    par_din = OFS_W'(v);
    @(negedge clk);
    par_we = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ld_serial = 1'b0; fwft_sel = 1'b0; ser_en = 1'b0;
    ser_din = 1'b0; par_we = 1'b0; par_din = '0;
    wr_count = '0; rd_count = '0;

    // R10: reset values held while reset is active, whatever the count
    wr_count = 13'd4097; rd_count = 13'd4097;
    repeat (4) @(negedge clk);
    check("R10 reset value", 3'b011);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (i == 0 || VEC[i].fw != VEC[i-1].fw || VEC[i].ld != VEC[i-1].ld)
        do_reset(VEC[i].fw, VEC[i].ld);
      probe(int'(VEC[i].cnt), "R2/R3/R4/R5/R6/R7 table", VEC[i].exp);
    end

    // R10: one-edge latency
    do_reset(1'b0, 1'b0);
    probe(0, "R10 settle", 3'b011);
    wr_count = 13'd4096; rd_count = 13'd4096;
    #1 check("R10 before edge", 3'b011);
    @(negedge clk);
    check("R10 after edge", 3'b100);

    // R11: fwft_sel change after reset ignored (standard, n=127)
    fwft_sel = 1'b1;
    repeat (2) @(negedge clk);
    probe(128, "R11 mode held", 3'b111);

    // R8: serial load n=5, m=10, standard timing
    do_reset(1'b0, 1'b1);
    shift_ofs(5, 10);
    probe(5,    "R8 serial n", 3'b011);
    probe(6,    "R8 serial n", 3'b111);
    probe(4086, "R8 serial m", 3'b100);
    probe(4085, "R8 serial m", 3'b101);
    // R1: parallel strobe ignored in serial mode
    par_write(50);
    probe(6,    "R1 par ignored", 3'b111);
    // R8: sequence wraps back to n
    shift_ofs(7, 10);
    probe(7,    "R8 wrap", 3'b011);
    probe(8,    "R8 wrap", 3'b111);

    // R9: parallel alternation, fall-through timing
    do_reset(1'b1, 1'b0);
    par_write(20);
    par_write(30);
    probe(21,   "R9 par n", 3'b011);
    probe(22,   "R9 par n", 3'b111);
    probe(4067, "R9 par m", 3'b100);
    probe(4066, "R9 par m", 3'b101);
    // R1: serial bits ignored in parallel mode
    shift_ofs(1023, 1023);
    probe(22,   "R1 ser ignored", 3'b111);
    probe(4066, "R1 ser ignored", 3'b101);
    // R9: third write returns to n
    par_write(40);
    probe(41,   "R9 third to n", 3'b011);
    probe(4066, "R9 m kept", 3'b101);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung, expected done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule